// File: doc/BRIEF.md
# Microcoded Nibble ALU Datapath

This block is the 4-bit arithmetic path of a small microcontroller core. Each instruction cycle it receives a word of already-decoded control bits, one bit per action. Some bits place operands onto two adder input buses, called the positive and the negative bus. Other bits choose the carry-in, pick where the adder result is written (the accumulator, the Y register, or both), and choose which conditions may clear the status flag. The operand sources are the accumulator and its complement, the Y register, a memory read nibble, a constant/input nibble and an auxiliary nibble and its complement. The negative bus can also carry the constant fifteen.

When several sources are enabled onto the same bus, their values combine by bitwise OR. A bus with no source enabled reads as zero. The status flag starts each cycle at 1. Each enabled condition can clear it: the adder carry-out, the inequality of the two buses, or a separately sampled special flag. The status value can be copied into a status latch that holds until it is copied again. The block also produces the memory write data and the write strobe. A conditional-enable bit can gate that strobe with the current status.

All register updates take place on one rising clock edge at the end of the cycle. Instruction decoding, RAM addressing and the I/O pins sit outside this block.

Top module: `nibble_alu_path`

## Requirements
- R1: While reset is asserted, and after it is released until the first edge with a control bit set, the accumulator, Y and the status latch read 0 and the status reads 1.
- R2: Control bits 8 (constant nibble), 10 (memory nibble), 15 (Y), 17 (auxiliary nibble) and 18 (inverted auxiliary nibble) each enable one source onto the positive bus. All enabled sources are ORed together, and with none enabled the bus is 0.
- R3: Control bits 0 (constant 15), 1 (accumulator), 7 (constant nibble), 9 (memory nibble) and 11 (inverted accumulator) each enable one source onto the negative bus. All enabled sources are ORed together, and with none enabled the bus is 0.
- R4: The adder produces positive bus + negative bus + carry-in, where carry-in is control bit 5, modulo 16. Bit 2 writes this sum into the accumulator and bit 3 writes it into Y; both may be written in the same edge. A register whose write bit is clear keeps its value.
- R5: With control bit 4 set, the status after the edge is cleared when the 5-bit sum has no carry into bit 4.
- R6: With control bit 12 set, the status after the edge is cleared when the two buses are equal. When bits 4 and 12 are both set, the two conditions are ANDed.
- R7: With none of control bits 4, 12 and 19 set, the status after the edge is 1.
- R8: Control bit 14 copies the status value present before the edge into the status latch. Without bit 14, the latch holds its value.
- R9: The memory write data is the accumulator when bit 13 is set, ORed with the constant nibble when bit 6 is set, and 0 when neither bit is set. The write strobe is high when bit 13 or bit 6 is set.
- R10: With control bit 16 set, the write strobe is additionally forced low while the status is 0.
- R11: Control bit 20 samples the adder carry-out into an internal special flag, which resets to 0. With control bit 19 set, the status after the edge is ANDed with that special flag as it stood before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction cycle per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl | input | 21 | Decoded control word, one bit per action |
| mem_rd | input | 4 | Memory read nibble |
| ckb | input | 4 | Constant / input nibble |
| dam | input | 4 | Auxiliary nibble |
| acc | output | 4 | Accumulator |
| y_reg | output | 4 | Y register |
| mem_wd | output | 4 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| status | output | 1 | Status flag |
| slatch | output | 1 | Status latch |

## Verification
A source that is missing from a bus, or enabled onto the wrong one, shows up in the accumulator or Y one edge after the cycle that should have used it. A carry or compare that is taken the wrong way shows up as a wrong status on that same edge. A wrong special flag stays hidden until a later cycle sets bit 19. A latch that copies at the wrong time differs from the expected value as soon as the status and latch values diverge. Write data and strobe errors are visible within the same cycle, before any edge.

// File: rtl/nibble_alu_path.sv
module nibble_alu_path #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [20:0]  ctl,
  input  logic [W-1:0] mem_rd,
  input  logic [W-1:0] ckb,
  input  logic [W-1:0] dam,
  output logic [W-1:0] acc,
  output logic [W-1:0] y_reg,
  output logic [W-1:0] mem_wd,
  output logic         mem_we,
  output logic         status,
  output logic         slatch
);

  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [W-1:0] pbus, nbus;
  logic [W:0]   sum;
  logic         carry, differ, sflag, status_nx;

  assign pbus = ({W{ctl[8]}}  & ckb)
              | ({W{ctl[10]}} & mem_rd)
              | ({W{ctl[15]}} & y_reg)
              | ({W{ctl[17]}} & dam)
              | ({W{ctl[18]}} & ~dam);

  assign nbus = ({W{ctl[0]}}  & ALL1)
              | ({W{ctl[1]}}  & acc)
              | ({W{ctl[7]}}  & ckb)
              | ({W{ctl[9]}}  & mem_rd)
              | ({W{ctl[11]}} & ~acc);

  assign sum    = {1'b0, pbus} + {1'b0, nbus} + {{W{1'b0}}, ctl[5]};
  assign carry  = sum[W];
  assign differ = (pbus != nbus);

  assign status_nx = (~ctl[4]  | carry)
                   & (~ctl[12] | differ)
                   & (~ctl[19] | sflag);

  assign mem_wd = ({W{ctl[13]}} & acc) | ({W{ctl[6]}} & ckb);
  assign mem_we = (ctl[13] | ctl[6]) & (~ctl[16] | status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      y_reg  <= '0;
      status <= 1'b1;
      slatch <= 1'b0;
      sflag  <= 1'b0;
    end else begin
      if (ctl[2])  acc    <= sum[W-1:0];
      if (ctl[3])  y_reg  <= sum[W-1:0];
      if (ctl[14]) slatch <= status;
      if (ctl[20]) sflag  <= carry;
      status <= status_nx;
    end
  end

endmodule

// File: rtl/nibble_alu_path_chk.sv
module nibble_alu_path_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [20:0]  ctl,
  input logic [W-1:0] acc,
  input logic [W-1:0] y_reg,
  input logic         mem_we,
  input logic         status,
  input logic         slatch
);

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[2] |=> $stable(acc)); // R4
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[3] |=> $stable(y_reg)); // R4
  AST_STATUS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[4] && !ctl[12] && !ctl[19]) |=> status); // R7
  AST_SLATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[14] |=> $stable(slatch)); // R8
  AST_SLATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[14] |=> (slatch == $past(status))); // R8
  AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl[13] || ctl[6]) |-> !mem_we); // R9
  AST_COND_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[16] && !status) |-> !mem_we); // R10

endmodule

bind nibble_alu_path nibble_alu_path_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .acc(acc), .y_reg(y_reg),
  .mem_we(mem_we), .status(status), .slatch(slatch)
);

// File: tb/nibble_alu_path_test.sv
module nibble_alu_path_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] ctl = '0;
  logic [3:0]  mem_rd = '0, ckb = '0, dam = '0;
  logic [3:0]  acc, y_reg, mem_wd;
  logic        mem_we, status, slatch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  nibble_alu_path uut (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rd(mem_rd), .ckb(ckb), .dam(dam),
    .acc(acc), .y_reg(y_reg), .mem_wd(mem_wd), .mem_we(mem_we),
    .status(status), .slatch(slatch)
  );

  localparam logic [20:0] K15N = 21'd1 << 0,  KAN  = 21'd1 << 1,  KTOA = 21'd1 << 2;
  localparam logic [20:0] KTOY = 21'd1 << 3,  KC8  = 21'd1 << 4,  KCIN = 21'd1 << 5;
  localparam logic [20:0] KCKM = 21'd1 << 6,  KCKN = 21'd1 << 7,  KCKP = 21'd1 << 8;
  localparam logic [20:0] KMN  = 21'd1 << 9,  KMP  = 21'd1 << 10, KNAN = 21'd1 << 11;
  localparam logic [20:0] KNE  = 21'd1 << 12, KSTO = 21'd1 << 13, KSTL = 21'd1 << 14;
  localparam logic [20:0] KYP  = 21'd1 << 15, KCME = 21'd1 << 16, KDP  = 21'd1 << 17;
  localparam logic [20:0] KNDP = 21'd1 << 18, KSSE = 21'd1 << 19, KSSS = 21'd1 << 20;

  typedef struct packed {
    logic [20:0] c;
    logic [3:0]  m, k, d, ea, ey;
    logic        es;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{KCKP|KMP|KTOA,            4'h3, 4'h4, 4'h0, 4'h7, 4'h0, 1'b1}, // R2 or
    '{KAN|KYP|KTOY|KC8,         4'h0, 4'h0, 4'h0, 4'h7, 4'h7, 1'b0}, // R5 no carry
    '{K15N|KCKP|KCIN|KTOA|KC8,  4'h0, 4'h1, 4'h0, 4'h1, 4'h7, 1'b1}, // R4 cin
    '{KNAN|KDP|KTOA|KTOY|KC8,   4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 1'b1}, // R4 both
    '{KMP|KCKN|KNE,             4'h5, 4'h5, 4'h0, 4'h0, 4'h0, 1'b0}, // R6 equal
    '{KMP|KCKN|KNE|KC8,         4'h5, 4'h4, 4'h0, 4'h0, 4'h0, 1'b0}, // R6 and
    '{KNDP|K15N|KTOA,           4'h0, 4'h0, 4'h3, 4'hB, 4'h0, 1'b1}, // R7
    '{KMN|KCKN|KCKP|KTOY|KNE,   4'h2, 4'h8, 4'h0, 4'hB, 4'h2, 1'b1}  // R3 or
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [20:0] c, input logic [3:0] m, input logic [3:0] k,
                      input logic [3:0] d);
    ctl = c; mem_rd = m; ckb = k; dam = d;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 acc", acc, 0); chk("R1 y", y_reg, 0);
    chk("R1 status", status, 1); chk("R1 slatch", slatch, 0);
    rst_n = 1'b1;
    step('0, 0, 0, 0);
    chk("R1 acc after release", acc, 0); chk("R1 status after release", status, 1);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].c, TBL[i].m, TBL[i].k, TBL[i].d);
      chk("R2/R3/R4 acc", acc, TBL[i].ea);
      chk("R2/R3/R4 y", y_reg, TBL[i].ey);
      chk("R5/R6/R7 status", status, TBL[i].es);
    end

    // R8 latch copy, hold, copy of 0
    step(KSTL, 0, 0, 0);
    chk("R8 copy 1", slatch, 1);
    step(KC8, 0, 0, 0);
    chk("R5 status 0", status, 0); chk("R8 hold", slatch, 1);
    step(KSTL, 0, 0, 0);
    chk("R8 copy 0", slatch, 0); chk("R7 status", status, 1);

    // R9 write data and strobe (acc = B)
    ctl = KSTO | KCKM; ckb = 4'h4; #1;
    chk("R9 or data", mem_wd, 4'hF); chk("R9 strobe", mem_we, 1);
    ctl = KSTO; #1;
    chk("R9 acc data", mem_wd, 4'hB); chk("R9 strobe sto", mem_we, 1);
    ctl = '0; #1;
    chk("R9 idle data", mem_wd, 0); chk("R9 idle strobe", mem_we, 0);

    // R10 conditional strobe
    ctl = KCME | KSTO; #1;
    chk("R10 status 1 strobe", mem_we, 1);
    step(KC8, 0, 0, 0);
    chk("R10 status cleared", status, 0);
    ctl = KCME | KSTO; #1;
    chk("R10 gated strobe", mem_we, 0);
    ctl = KCKM; ckb = 4'h6; #1;
    chk("R10 ungated strobe", mem_we, 1);
    step('0, 0, 0, 0);

    // R11 special flag
    step(KSSE, 0, 0, 0);
    chk("R11 reset flag clears", status, 0);
    step(K15N | KCKP | KSSS, 0, 4'h1, 0);
    chk("R11 sample no effect", status, 1);
    step(KSSE, 0, 0, 0);
    chk("R11 flag 1", status, 1);
    step(KSSS, 0, 0, 0);
    step(KSSE, 0, 0, 0);
    chk("R11 flag 0", status, 0);

    // R1 mid-run reset
    step(K15N | KTOA | KTOY | KSTL, 0, 0, 0);
    rst_n = 1'b0;
    step('0, 0, 0, 0);
    chk("R1 acc", acc, 0); chk("R1 y", y_reg, 0);
    chk("R1 status", status, 1); chk("R1 slatch", slatch, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule